// File: doc/BRIEF.md
# Paired-Instruction Accumulator Core

A compact accumulator processor that follows the classic stored-program fetch-execute loop. Each 40-bit memory word carries two 20-bit instructions. One instruction read brings in both halves. The first half goes to the instruction register and the other half waits in a buffer register. When the first half finishes, the buffered half executes at once, with no second read of the word. The program counter advances only after both halves have run.

A single synchronous memory port carries instruction fetches, operand reads and stores. Reads have a fixed latency of one cycle, and the memory's registered read output serves as the memory buffer register. An accumulator holds every arithmetic result. A multiplier-quotient register receives the low half of a double-length product.

Jumps name a target word, and the opcode's lowest bit chooses which half of that word runs first. A taken jump throws away any instruction still waiting in the buffer. The core stops on a halt instruction. It also stops on any opcode it does not recognise, and in that case it raises an error flag.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high, `pc`, `acc` and `mq` read zero, `halted` and `error` are low, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: Every word is `{right, left}`, with the left instruction in bits 19:0 and the right in bits 39:20. Within each instruction the opcode sits in its top 8 bits and the address in its low 12 bits. A fetch reads the word at `pc`, and the left half executes before the right.
- R3: The right half executes without another read of the instruction word. A word whose two halves need no operand reads takes one read, and a left+right pair takes 7 cycles (4 for the left, 3 for the right).
- R4: `pc` changes only at the end of an execute step. Without a jump it increments by one once both halves of the word have completed.
- R5: Opcode 0x01 loads the addressed word into `acc`. Opcode 0x03 adds the addressed word to `acc` and 0x04 subtracts it, both modulo 2^40.
- R6: Opcode 0x02 writes `acc` to the addressed word. Read and write are never asserted together.
- R7: Opcode 0x05 forms the unsigned 80-bit product of `acc` and the addressed word. The upper 40 bits go to `acc` and the lower 40 bits to `mq`. Opcode 0x06 copies `mq` into `acc`.
- R8: Opcodes 0x08/0x09 always jump. Opcodes 0x0A/0x0B jump when bit 39 of `acc` is 0. Bit 0 of the opcode set to 1 starts the target word at its right half, and its left half is skipped. A taken jump discards the buffered right half.
- R9: A conditional jump with a negative `acc` falls through to the next instruction.
- R10: Opcode 0x00 sets `halted` and leaves `error` low. After that, no memory access occurs and `halted` stays set.
- R11: Any other opcode sets both `halted` and `error` and leaves `acc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 40 | Store data |
| mem_rdata | input | 40 | Registered read data |
| acc | output | 40 | Accumulator |
| mq | output | 40 | Multiplier-quotient register |
| pc | output | 12 | Program counter (word address) |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Stop was caused by an unknown opcode |

## Verification
Some properties must hold on every cycle, and the assertions check those. The port stays quiet during reset and never reads and writes in the same cycle. No read is issued while the buffered half is promoted into the instruction register. `pc` holds steady outside execute steps. Once the core halts it stays halted and silent, and an error always comes with a halt. Other behaviours depend on a whole program's outcome, and only the bench's programs can show them. These are the arithmetic results, the split of the product between `acc` and `mq`, and which half of a jump target runs first. The bench also confirms that a discarded buffered half really never executes, and it checks the exact cycle and read counts for one instruction pair.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_HALT  = 8'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OPC_ADD   = 8'h03;
  localparam logic [OPC_W-1:0] OPC_SUB   = 8'h04;
  localparam logic [OPC_W-1:0] OPC_MUL   = 8'h05;
  localparam logic [OPC_W-1:0] OPC_MQACC = 8'h06;
  localparam logic [OPC_W-1:0] OPC_JMPL  = 8'h08;
  localparam logic [OPC_W-1:0] OPC_JMPR  = 8'h09;
  localparam logic [OPC_W-1:0] OPC_JGEL  = 8'h0A;
  localparam logic [OPC_W-1:0] OPC_JGER  = 8'h0B;

  typedef enum logic [2:0] {
    ST_FETCH, ST_UNPACK, ST_OPERAND, ST_EXECUTE, ST_NEXT_HALF, ST_HALT
  } state_t;

  typedef enum logic [2:0] {
    ALU_NONE, ALU_LOAD, ALU_ADD, ALU_SUB, ALU_MUL, ALU_MQ
  } alu_op_t;

  typedef struct packed {
    logic    rd_op;
    logic    wr_op;
    logic    jump;
    logic    jump_cond;
    logic    to_right;
    logic    stop;
    logic    bad;
    alu_op_t alu;
  } dec_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);
  always_comb begin
    dec = '0;
    dec.alu = ALU_NONE;
    case (opc)
      OPC_HALT:  dec.stop = 1'b1;
      OPC_LOAD:  begin dec.rd_op = 1'b1; dec.alu = ALU_LOAD; end
      OPC_STORE: dec.wr_op = 1'b1;
      OPC_ADD:   begin dec.rd_op = 1'b1; dec.alu = ALU_ADD; end
      OPC_SUB:   begin dec.rd_op = 1'b1; dec.alu = ALU_SUB; end
      OPC_MUL:   begin dec.rd_op = 1'b1; dec.alu = ALU_MUL; end
      OPC_MQACC: dec.alu = ALU_MQ;
      OPC_JMPL, OPC_JMPR, OPC_JGEL, OPC_JGER: begin
        dec.jump      = 1'b1;
        dec.jump_cond = opc[1];
        dec.to_right  = opc[0];
      end
      default:   dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 40
) (
  input  alu_op_t           op,
  input  logic [DATA_W-1:0] acc_q,
  input  logic [DATA_W-1:0] mq_q,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] acc_n,
  output logic [DATA_W-1:0] mq_n
);
  localparam int PROD_W = 2 * DATA_W;
  logic [PROD_W-1:0] prod;

  assign prod = {{DATA_W{1'b0}}, acc_q} * {{DATA_W{1'b0}}, opnd};

  always_comb begin
    acc_n = acc_q;
    mq_n  = mq_q;
    case (op)
      ALU_LOAD: acc_n = opnd;
      ALU_ADD:  acc_n = acc_q + opnd;
      ALU_SUB:  acc_n = acc_q - opnd;
      ALU_MUL:  begin
        acc_n = prod[PROD_W-1:DATA_W];
        mq_n  = prod[DATA_W-1:0];
      end
      ALU_MQ:   acc_n = mq_q;
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_unpack.sv
module acc_unpack #(
  parameter int HALF_W = 20
) (
  input  logic [2*HALF_W-1:0] word,
  input  logic                right_first,
  output logic [HALF_W-1:0]   first_h,
  output logic [HALF_W-1:0]   right_h
);
  logic [HALF_W-1:0] halves [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = word[h*HALF_W +: HALF_W];
  end

  assign first_h = right_first ? halves[1] : halves[0];
  assign right_h = halves[1];
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         mem_rd,
  output logic                         mem_wr,
  output logic [2*(OPC_W+ADDR_W)-1:0]  mem_wdata,
  input  logic [2*(OPC_W+ADDR_W)-1:0]  mem_rdata,
  output logic [2*(OPC_W+ADDR_W)-1:0]  acc,
  output logic [2*(OPC_W+ADDR_W)-1:0]  mq,
  output logic [ADDR_W-1:0]            pc,
  output logic                         halted,
  output logic                         error
);
  localparam int HALF_W = OPC_W + ADDR_W;
  localparam int DATA_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  state_t              state;
  logic [ADDR_W-1:0]   mar;
  logic [HALF_W-1:0]   ir, ibr;
  logic                ibr_vld, start_right;
  logic [HALF_W-1:0]   first_h, right_h;
  logic [DATA_W-1:0]   acc_n, mq_n;
  logic [OPC_W-1:0]    ir_op;
  logic [ADDR_W-1:0]   ir_addr;
  dec_t                dec;
  logic                take;

  assign ir_op   = ir[HALF_W-1 -: OPC_W];
  assign ir_addr = ir[ADDR_W-1:0];

  acc_decode u_dec (.opc(ir_op), .dec(dec));

  acc_unpack #(.HALF_W(HALF_W)) u_unpack (
    .word(mem_rdata), .right_first(start_right),
    .first_h(first_h), .right_h(right_h)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op(dec.alu), .acc_q(acc), .mq_q(mq), .opnd(mem_rdata),
    .acc_n(acc_n), .mq_n(mq_n)
  );

  assign take = dec.jump && (!dec.jump_cond || !acc[DATA_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FETCH;
      pc          <= '0;
      mar         <= '0;
      ir          <= '0;
      ibr         <= '0;
      ibr_vld     <= 1'b0;
      start_right <= 1'b0;
      acc         <= '0;
      mq          <= '0;
      halted      <= 1'b0;
      error       <= 1'b0;
    end else begin
      case (state)
        ST_FETCH:  state <= ST_UNPACK;
        ST_UNPACK: begin
          ir          <= first_h;
          ibr         <= right_h;
          ibr_vld     <= !start_right;
          start_right <= 1'b0;
          state       <= ST_OPERAND;
        end
        ST_OPERAND: begin
          mar   <= ir_addr;
          state <= ST_EXECUTE;
        end
        ST_EXECUTE: begin
          acc <= acc_n;
          mq  <= mq_n;
          if (dec.bad) begin
            halted <= 1'b1;
            error  <= 1'b1;
            state  <= ST_HALT;
          end else if (dec.stop) begin
            halted <= 1'b1;
            state  <= ST_HALT;
          end else if (take) begin
            pc          <= mar;
            start_right <= dec.to_right;
            ibr_vld     <= 1'b0;
            state       <= ST_FETCH;
          end else if (ibr_vld) begin
            state <= ST_NEXT_HALF;
          end else begin
            pc    <= pc + PC_STEP;
            state <= ST_FETCH;
          end
        end
        ST_NEXT_HALF: begin
          ir      <= ibr;
          ibr_vld <= 1'b0;
          state   <= ST_OPERAND;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = mar;
    mem_wdata = acc;
    if (!rst) begin
      case (state)
        ST_FETCH:   begin mem_rd = 1'b1; mem_addr = pc; end
        ST_OPERAND: begin mem_rd = dec.rd_op; mem_addr = ir_addr; end
        ST_EXECUTE: mem_wr = dec.wr_op;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] pc,
  input logic              halted,
  input logic              error,
  input state_t            state
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (!mem_rd && !mem_wr)); // R1

  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R6

  AST_HALF_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NEXT_HALF) |-> !mem_rd); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_EXECUTE) |=> $stable(pc)); // R4

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_rd && !mem_wr)); // R10

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    error |-> halted); // R11
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .pc(pc), .halted(halted), .error(error), .state(state)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
  localparam int AW = 12;
  localparam int DW = 40;
  localparam int RUN_LIMIT = 2000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata, acc, mq;
  logic [AW-1:0] pc;
  logic          halted, error;

  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] mem [4096];

  int checks = 0;
  int errors = 0;
  int run_cyc, run_rd, run_rd0;

  always #2.5 clk = ~clk;

  acc_core #(.ADDR_W(AW)) u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc(acc), .mq(mq), .pc(pc), .halted(halted), .error(error)
  );

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  typedef struct packed {
    logic [DW-1:0] w0, w1, w2, w3, d0, d1, e_acc, e_mq, e_m102;
    logic          e_err;
  } vec_t;

  // words are {right, left}; data at 0x100/0x101, store target 0x102
  localparam vec_t VECS [11] = '{
    '{40'h03101_01100, 40'h0, 40'h0, 40'h0, 40'd5, 40'd7, 40'd12, 40'h0, 40'h0, 1'b0},
    '{40'h04101_01100, 40'h0, 40'h0, 40'h0, 40'd3, 40'd5, 40'hFF_FFFF_FFFE, 40'h0, 40'h0, 1'b0},
    '{40'h05101_01100, 40'h0, 40'h0, 40'h0, 40'h10_0000_0003, 40'h100, 40'h10, 40'h300, 40'h0, 1'b0},
    '{40'h05101_01100, 40'h00000_06000, 40'h0, 40'h0, 40'h10_0000_0003, 40'h100, 40'h300, 40'h300, 40'h0, 1'b0},
    '{40'h01101_09002, 40'h0, 40'h03100_03100, 40'h0, 40'd9, 40'd4, 40'd9, 40'h0, 40'h0, 1'b0},
    '{40'h0A002_01100, 40'h00000_01101, 40'h00000_03101, 40'h0, 40'd9, 40'd4, 40'd13, 40'h0, 40'h0, 1'b0},
    '{40'h0A002_01100, 40'h00000_01101, 40'h00000_03101, 40'h0, 40'h80_0000_0000, 40'd4, 40'd4, 40'h0, 40'h0, 1'b0},
    '{40'h7F000_01100, 40'h0, 40'h0, 40'h0, 40'd9, 40'd4, 40'd9, 40'h0, 40'h0, 1'b1},
    '{40'h03101_01100, 40'h01101_02102, 40'h0, 40'h0, 40'd9, 40'd4, 40'd4, 40'h0, 40'd13, 1'b0},
    '{40'h01100_00000, 40'h0, 40'h0, 40'h0, 40'd9, 40'd4, 40'h0, 40'h0, 40'h0, 1'b0},
    '{40'h01100_08002, 40'h00000_01101, 40'h00000_03100, 40'h0, 40'd9, 40'd4, 40'd9, 40'h0, 40'h0, 1'b0}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R5_add";     1: return "R5_sub_wrap";
      2: return "R7_mul";     3: return "R7_mq_copy";
      4: return "R8_jmp_right"; 5: return "R8_jge_taken";
      6: return "R9_jge_fall"; 7: return "R11_bad_opcode";
      8: return "R6_store";   9: return "R10_halt_left";
      default: return "R8_jmp_left";
    endcase
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_and_run(input vec_t v);
    rst = 1'b1;
    poke(12'h000, v.w0); poke(12'h001, v.w1);
    poke(12'h002, v.w2); poke(12'h003, v.w3);
    poke(12'h100, v.d0); poke(12'h101, v.d1);
    poke(12'h102, 40'h0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    run_cyc = 0; run_rd = 0; run_rd0 = 0;
    while (!halted && run_cyc < RUN_LIMIT) begin
      if (mem_rd) begin
        run_rd++;
        if (mem_addr == 12'h000) run_rd0++;
      end
      @(posedge clk);
      run_cyc++;
      @(negedge clk);
    end
    check(DW'(halted), DW'(1), "run_terminates");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(DW'(pc), DW'(0), "R1_pc");
    check(acc, DW'(0), "R1_acc");
    check(mq, DW'(0), "R1_mq");
    check(DW'({halted, error}), DW'(0), "R1_flags");
    check(DW'({mem_rd, mem_wr}), DW'(0), "R1_quiet_port");

    for (int i = 0; i < 11; i++) begin
      load_and_run(VECS[i]);
      check(acc, VECS[i].e_acc, {vec_req(i), "_acc"});
      check(mq, VECS[i].e_mq, {vec_req(i), "_mq"});
      check(DW'(error), DW'(VECS[i].e_err), {vec_req(i), "_err"});
      check(mem[12'h102], VECS[i].e_m102, {vec_req(i), "_mem"});
    end

    // R2 R3 R4: one fetch serves both halves; exact cycles and reads
    load_and_run('{40'h03101_01100, 40'h0, 40'h0, 40'h0, 40'd2, 40'd3,
                   40'd0, 40'h0, 40'h0, 1'b0});
    check(acc, DW'(5), "R2_left_then_right");
    check(DW'(run_cyc), DW'(11), "R3_cycle_count");
    check(DW'(run_rd), DW'(4), "R3_read_count");
    check(DW'(run_rd0), DW'(1), "R3_single_fetch");
    check(DW'(pc), DW'(1), "R4_pc_after_pair");

    // R10: halt is sticky and silent
    repeat (5) begin
      @(negedge clk);
      check(DW'({halted, mem_rd, mem_wr}), DW'(3'b100), "R10_sticky");
    end

    // R1: reset mid-run clears state
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(DW'({pc, halted, error}), DW'(0), "R1_reassert");
    check(acc, DW'(0), "R1_reassert_acc");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule